// File: doc/BRIEF.md
# Shadowed Position Compare Unit

This block watches a 32-bit position count and signals when the count arrives at a programmed compare value. When it arrives, the block raises a sticky match flag and emits a single-cycle event strobe. It also drives a sync output whose pulse is stretched to a programmed width and whose active level can be chosen. The arrival can come from either counting direction.

The compare value can be written straight into the active register. It can also be staged in a shadow register, which is copied into the active register on a chosen event: either a compare match or a counter-zero strobe. Every such copy raises a sticky ready flag. Software clears both flags by pulsing their clear strobes. Producing the count, decoding the encoder and combining interrupts are left to neighbouring blocks.

Top module: `pos_cmp_unit`

## Requirements
- R1: After reset, cmp_value is 0, match_flag, ready_flag and match_evt are 0, and sync_out sits at its inactive level (the inverse of sync_pol).
- R2: With shadow_en = 0, a cycle with wr_cmp = 1 puts wr_data into cmp_value at the next clock edge.
- R3: With shadow_en = 1, wr_cmp writes only the shadow register, and cmp_value keeps its value until a load occurs.
- R4: With shadow_en = 1 and load_sel = 0, a match copies the shadow value into cmp_value at the same edge that raises match_evt. The match itself is judged against the old active value.
- R5: With shadow_en = 1 and load_sel = 1, a cycle with cnt_zero = 1 copies the shadow value into cmp_value at the next edge. A load always takes the shadow value held before any write made in that same cycle.
- R6: Every shadow-to-active load sets ready_flag at the same edge that updates cmp_value.
- R7: A match occurs in a cycle where pos_cnt equals the active compare value and the pos_cnt of the previous cycle did not. This applies whether the count rose or fell onto the value. A count that stays on the compare value matches only once.
- R8: match_flag and ready_flag are sticky. A cycle with clr_match or clr_ready = 1 clears the flag at the next edge. If a set and a clear of the same flag fall in one cycle, the flag ends up set.
- R9: match_evt is high for exactly the one cycle after each match cycle.
- R10: A match starts a pulse that lasts pulse_width + 1 cycles, starting with the cycle in which match_evt is high. A match during a pulse restarts the full width.
- R11: With sync_pol = 1, sync_out is high while the pulse is active. With sync_pol = 0, sync_out is low while the pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pos_cnt | input | 32 | Current position count |
| cnt_zero | input | 1 | Strobe: the counter passed through zero this cycle |
| wr_cmp | input | 1 | Write strobe for the compare value |
| wr_data | input | 32 | Compare value to write |
| shadow_en | input | 1 | 1 = writes go to the shadow register |
| load_sel | input | 1 | Shadow load event: 0 = match, 1 = counter zero |
| sync_pol | input | 1 | Sync output level: 1 = active high, 0 = active low |
| pulse_width | input | 12 | Pulse length minus one, in cycles |
| clr_match | input | 1 | Clear strobe for match_flag |
| clr_ready | input | 1 | Clear strobe for ready_flag |
| sync_out | output | 1 | Stretched sync pulse |
| match_evt | output | 1 | One-cycle match strobe |
| match_flag | output | 1 | Sticky match flag |
| ready_flag | output | 1 | Sticky load-ready flag |
| cmp_value | output | 32 | Active compare value |

## Verification
The assertions assume that the control inputs are synchronous to clk and hold steady around each edge. They also assume that pulse_width is not changed in the cycle a pulse starts when the width is compared afterwards. The bench changes every input only well after a clock edge. In the directed part it moves the count one step at a time in both directions, and in the random part it mixes steps, holds and jumps with random strobes and mode changes. A behavioural model in the bench follows the same inputs and is compared with every output on each cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic {
    LOAD_ON_MATCH = 1'b0,
    LOAD_ON_ZERO  = 1'b1
  } load_evt_e;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_MATCH = 0;
  localparam int unsigned FLAG_READY = 1;
endpackage

// File: rtl/pcu_match_det.sv
module pcu_match_det #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] pos_cnt,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             hit,
  output logic             hit_q
);
  logic [CNT_W-1:0] prev_q, prev_d;
  logic             hit_d;

  always_comb begin
    hit    = (pos_cnt == cmp_val) && (prev_q != cmp_val);
    hit_d  = hit;
    prev_d = pos_cnt;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      hit_q  <= hit_d;
    end
  end

  AST_EVT_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_ni)
    hit_q |-> $past(pos_cnt == cmp_val)); // R7
endmodule

// File: rtl/pcu_cmp_regs.sv
module pcu_cmp_regs #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             shadow_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load,
  output logic [CNT_W-1:0] active_q,
  output logic [CNT_W-1:0] shadow_q
);
  logic [CNT_W-1:0] active_d, shadow_d;
  logic             active_en, shadow_en_wr;

  always_comb begin
    shadow_en_wr = wr_en && shadow_en;
    active_en    = load || (wr_en && !shadow_en);
    shadow_d     = wr_data;
    active_d     = load ? shadow_q : wr_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      shadow_q <= '0;
    end else begin
      if (active_en)    active_q <= active_d;
      if (shadow_en_wr) shadow_q <= shadow_d;
    end
  end

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!shadow_en && wr_en) |=> active_q == $past(wr_data)); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (shadow_en && !load) |=> $stable(active_q)); // R3
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_ni)
    load |=> active_q == $past(shadow_q)); // R4
endmodule

// File: rtl/pcu_sticky_flag.sv
module pcu_sticky_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    set |=> flag_q); // R8
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr && !set) |=> !flag_q); // R8
endmodule

// File: rtl/pcu_stretch.sv
module pcu_stretch #(
  parameter int unsigned PW_W = 12
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            start,
  input  logic [PW_W-1:0] width,
  output logic            active_q
);
  logic [PW_W-1:0] cnt_q, cnt_d;
  logic            active_d;

  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    if (start) begin
      cnt_d    = width;
      active_d = 1'b1;
    end else if (active_q) begin
      if (cnt_q == '0) active_d = 1'b0;
      else             cnt_d    = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_ni)
    start |=> (active_q && cnt_q == $past(width))); // R10
  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_ni)
    (active_q && cnt_q == '0 && !start) |=> !active_q); // R10
endmodule

// File: rtl/pos_cmp_unit.sv
module pos_cmp_unit #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PW_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] pos_cnt,
  input  logic             cnt_zero,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             shadow_en,
  input  logic             load_sel,
  input  logic             sync_pol,
  input  logic [PW_W-1:0]  pulse_width,
  input  logic             clr_match,
  input  logic             clr_ready,
  output logic             sync_out,
  output logic             match_evt,
  output logic             match_flag,
  output logic             ready_flag,
  output logic [CNT_W-1:0] cmp_value
);
  import pcu_pkg::*;

  logic [1:0]           rst_sync_q;
  logic                 rst_ni;
  logic                 hit, load, pulse_act;
  logic [CNT_W-1:0]     shadow_val;
  load_evt_e            load_evt;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pcu_match_det #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_ni(rst_ni), .pos_cnt(pos_cnt), .cmp_val(cmp_value),
    .hit(hit), .hit_q(match_evt)
  );

  always_comb begin
    load_evt = load_evt_e'(load_sel);
    load     = shadow_en && ((load_evt == LOAD_ON_ZERO) ? cnt_zero : hit);
  end

  pcu_cmp_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .shadow_en(shadow_en), .wr_en(wr_cmp),
    .wr_data(wr_data), .load(load), .active_q(cmp_value), .shadow_q(shadow_val)
  );

  always_comb begin
    flag_set             = '0;
    flag_clr             = '0;
    flag_set[FLAG_MATCH] = hit;
    flag_set[FLAG_READY] = load;
    flag_clr[FLAG_MATCH] = clr_match;
    flag_clr[FLAG_READY] = clr_ready;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    pcu_sticky_flag u_flag (
      .clk(clk), .rst_ni(rst_ni), .set(flag_set[g]), .clr(flag_clr[g]),
      .flag_q(flag_q[g])
    );
  end

  assign match_flag = flag_q[FLAG_MATCH];
  assign ready_flag = flag_q[FLAG_READY];

  pcu_stretch #(.PW_W(PW_W)) u_stretch (
    .clk(clk), .rst_ni(rst_ni), .start(hit), .width(pulse_width),
    .active_q(pulse_act)
  );

  assign sync_out = sync_pol ? pulse_act : !pulse_act;

  AST_EVT_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    match_evt |-> match_flag); // R9
  AST_EVT_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    match_evt |-> (sync_out == sync_pol)); // R10
  AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_ni)
    load |=> ready_flag); // R6
  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    (shadow_en && load_sel && cnt_zero) |=> cmp_value == $past(shadow_val)); // R5
endmodule

// File: tb/test_pos_cmp_unit.sv
module test_pos_cmp_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pos_cnt, wr_data;
  logic        cnt_zero, wr_cmp, shadow_en, load_sel, sync_pol, clr_match, clr_ready;
  logic [11:0] pulse_width;
  logic        sync_out, match_evt, match_flag, ready_flag;
  logic [31:0] cmp_value;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_cmp, m_shadow, m_prev;
  bit          m_mf, m_rf, m_evt, m_act;
  int          m_left;

  always #4 clk = ~clk;

  pos_cmp_unit i_pos_cmp_unit (
    .clk(clk), .rst_n(rst_n), .pos_cnt(pos_cnt), .cnt_zero(cnt_zero),
    .wr_cmp(wr_cmp), .wr_data(wr_data), .shadow_en(shadow_en),
    .load_sel(load_sel), .sync_pol(sync_pol), .pulse_width(pulse_width),
    .clr_match(clr_match), .clr_ready(clr_ready), .sync_out(sync_out),
    .match_evt(match_evt), .match_flag(match_flag), .ready_flag(ready_flag),
    .cmp_value(cmp_value)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmp = 0; m_shadow = 0; m_prev = 0;
      m_mf = 0; m_rf = 0; m_evt = 0; m_act = 0; m_left = 0;
    end else begin
      bit hit, ld;
      logic [31:0] old_shadow;
      hit = (pos_cnt == m_cmp) && (m_prev != m_cmp);
      ld  = shadow_en && (load_sel ? cnt_zero : hit);
      old_shadow = m_shadow;
      if (shadow_en && wr_cmp) m_shadow = wr_data;
      if (ld) m_cmp = old_shadow;
      else if (!shadow_en && wr_cmp) m_cmp = wr_data;
      m_mf = hit ? 1'b1 : (clr_match ? 1'b0 : m_mf);
      m_rf = ld  ? 1'b1 : (clr_ready ? 1'b0 : m_rf);
      m_evt = hit;
      if (hit) begin
        m_act = 1; m_left = int'(pulse_width);
      end else if (m_act) begin
        if (m_left == 0) m_act = 0;
        else m_left--;
      end
      m_prev = pos_cnt;
    end
  end

  always @(posedge clk) begin
    #2;
    if (running) begin
      chk("R9 match_evt", {31'd0, match_evt}, {31'd0, m_evt});
      chk("R8 match_flag", {31'd0, match_flag}, {31'd0, m_mf});
      chk("R6 ready_flag", {31'd0, ready_flag}, {31'd0, m_rf});
      chk("R2 cmp_value", cmp_value, m_cmp);
      chk("R10 sync_out", {31'd0, sync_out}, {31'd0, (sync_pol ? m_act : !m_act)});
    end
  end

  task automatic step(input logic [31:0] p);
    pos_cnt = p;
    @(posedge clk);
    #3;
    wr_cmp = 0; cnt_zero = 0; clr_match = 0; clr_ready = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; pos_cnt = 0; wr_data = 0; cnt_zero = 0; wr_cmp = 0;
    shadow_en = 0; load_sel = 0; sync_pol = 1; pulse_width = 12'd2;
    clr_match = 0; clr_ready = 0;
    repeat (3) @(posedge clk);
    #3; rst_n = 1;
    repeat (4) step(0);
    chk("R1 cmp_value", cmp_value, 0);
    chk("R1 flags", {30'd0, match_flag, ready_flag}, 0);
    chk("R1 match_evt", {31'd0, match_evt}, 0);
    chk("R1 sync_out", {31'd0, sync_out}, 0);
    running = 1'b1;

    // R2 direct write
    wr_cmp = 1; wr_data = 5; step(0);
    chk("R2 direct write", cmp_value, 5);
    for (int i = 1; i < 5; i++) step(i);
    chk("R7 no early match", {31'd0, match_evt}, 0);
    step(5);
    chk("R7 forward arrival", {31'd0, match_evt}, 1);
    chk("R11 active high", {31'd0, sync_out}, 1);
    step(5);
    chk("R7 hold no refire", {31'd0, match_evt}, 0);
    step(5); step(6); step(7); step(6);
    step(5);
    chk("R7 reverse arrival", {31'd0, match_evt}, 1);

    // R8 clear and set-wins
    clr_match = 1; step(6);
    chk("R8 cleared", {31'd0, match_flag}, 0);
    clr_match = 1; step(5);
    chk("R8 set wins", {31'd0, match_flag}, 1);

    // R11 active low
    sync_pol = 0; step(6); step(6); step(6); step(6);
    chk("R11 idle high when active low", {31'd0, sync_out}, 1);
    step(5);
    chk("R11 pulse low", {31'd0, sync_out}, 0);

    // R3/R4 shadow, load on match
    sync_pol = 1; shadow_en = 1; load_sel = 0;
    wr_cmp = 1; wr_data = 20; clr_ready = 1; step(6);
    chk("R3 active kept", cmp_value, 5);
    step(4);
    step(5);
    chk("R4 load on match", cmp_value, 20);
    chk("R4 match on old value", {31'd0, match_evt}, 1);
    chk("R6 ready set", {31'd0, ready_flag}, 1);

    // R5 load on counter zero
    load_sel = 1; clr_ready = 1; wr_cmp = 1; wr_data = 40; step(6);
    chk("R5 before zero", cmp_value, 20);
    chk("R6 ready cleared", {31'd0, ready_flag}, 0);
    cnt_zero = 1; step(0);
    chk("R5 load on zero", cmp_value, 40);
    chk("R6 ready after zero load", {31'd0, ready_flag}, 1);

    // R10 restart during pulse
    shadow_en = 0; wr_cmp = 1; wr_data = 10; pulse_width = 12'd5; step(9);
    step(10); step(9); step(10);
    for (int i = 0; i < 5; i++) step(11);
    chk("R10 still active after restart", {31'd0, sync_out}, 1);
    step(11);
    chk("R10 ends after width+1", {31'd0, sync_out}, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [31:0] p;
      r = $urandom_range(0, 9);
      p = pos_cnt;
      if (r < 4) p = pos_cnt + 1;
      else if (r < 8) p = pos_cnt - 1;
      else if (r == 8) p = $urandom_range(0, 15);
      if ($urandom_range(0, 15) == 0) begin wr_cmp = 1; wr_data = $urandom_range(0, 15); end
      if ($urandom_range(0, 19) == 0) cnt_zero = 1;
      if ($urandom_range(0, 9) == 0) clr_match = 1;
      if ($urandom_range(0, 9) == 0) clr_ready = 1;
      if ($urandom_range(0, 49) == 0) shadow_en = ~shadow_en;
      if ($urandom_range(0, 49) == 0) load_sel = ~load_sel;
      if ($urandom_range(0, 49) == 0) sync_pol = ~sync_pol;
      if ($urandom_range(0, 49) == 0) pulse_width = 12'($urandom_range(0, 6));
      step(p);
    end
    running = 1'b0;
    finish_run();
  end
endmodule